// File: doc/BRIEF.md
# SAR Converter Conversion Sequencer

This block is the digital controller that times each conversion of a successive-approximation converter. It watches an active-low conversion-start input, a device reset input, a power-down input and two mode selects. It drives a busy flag, a hold command for the sampling stage, a one-cycle strobe that moves the result into the output shift register, and a flag that marks a calibration in progress. The comparator and DAC are not modelled. A counter counts out the conversion time, and the result word is taken from an input port at the end of that time.

Every asynchronous input passes through a synchronizer first. A falling edge on the start input then begins a conversion if the block is idle, not powered down and the acquisition window has elapsed. The conversion length depends on the mode: fast, normal or low-power. A high level on the device reset input aborts the conversion. Its falling edge starts a calibration, which is reported on busy. In fast mode a monitor checks that conversions follow one another closely enough. If they do not, it raises a sticky flag.

Top module: `adc_conv_seq`

## Requirements
- R1: A falling edge of `conv_start_n` that is accepted raises `busy` and `hold` on the third rising clock edge after the input is first sampled low, which is SYNC_STAGES+1 edges.
- R2: The conversion length in cycles of `busy` is set by the selects sampled at start: CONV_WARP for `sel_fast`=1 and `sel_lowpow`=0, CONV_IMP for `sel_fast`=0 and `sel_lowpow`=1, and CONV_NORM when both are 0 or both are 1.
- R3: `latch_stb` is high for exactly one cycle, the last cycle of `busy` in a conversion. At that edge `result` takes `res_in`, and `result` changes at no other time.
- R4: A start falling edge that arrives while `busy` is high, during either a conversion or a calibration, is ignored. The busy period keeps its length and no further conversion follows.
- R5: After `busy` falls, a start edge is accepted only if it reaches the controller at least ACQ_CYC cycles later. An earlier edge is ignored.
- R6: While `cal_rst` is high, any conversion is aborted. `busy` and `hold` go low, no `latch_stb` is issued and `result` keeps its value.
- R7: A falling edge of `cal_rst` starts a calibration. For CAL_CYC cycles `busy` and `cal_active` are high, `hold` stays low and `result` is unchanged.
- R8: While `pwr_dn` is high no new conversion starts. A conversion already in progress runs to its full length and latches its result.
- R9: After an accepted fast-mode start, `warp_err` is set if no further start is accepted within WARP_MAX cycles. The flag is sticky, and an accepted start in any other mode disarms the monitor.
- R10: `warp_err` is cleared by `cal_rst` high and by `rst_n` low.
- R11: After `rst_n` low, `busy`, `hold`, `latch_stb`, `cal_active`, `warp_err` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| conv_start_n | input | 1 | Conversion start; a falling edge begins a conversion |
| cal_rst | input | 1 | Device reset; high aborts, falling edge calibrates |
| pwr_dn | input | 1 | Power-down; blocks new conversions |
| sel_fast | input | 1 | Fast mode select |
| sel_lowpow | input | 1 | Low-power mode select |
| res_in | input | RES_W | Result word from the conversion model |
| busy | output | 1 | Conversion or calibration in progress |
| hold | output | 1 | Hold command to the sampling stage |
| latch_stb | output | 1 | One-cycle strobe that loads the result |
| cal_active | output | 1 | Calibration in progress |
| result | output | RES_W | Latched conversion result |
| warp_err | output | 1 | Sticky fast-mode interval violation |

## Verification
The conversion path is tried in two ways. Random runs pick all four select codes, so each mode length is checked and so is the treatment of the both-high code as normal. Start edges are placed one cycle on each side of the acquisition boundary, which tells an accepted start from one that was dropped too early. A further edge is driven inside a conversion and another inside a calibration, and these show that busy periods keep their length. The fast-mode interval is probed at the exact cycle the flag rises. Separate sequences confirm that the flag is sticky, that a normal start disarms it, and that both resets clear it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MD_NORMAL  = 2'd0,
    MD_WARP    = 2'd1,
    MD_IMPULSE = 2'd2
  } conv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_CAL  = 2'd2,
    ST_HALT = 2'd3
  } seq_state_e;

  function automatic conv_mode_e decode_mode(input logic fast, input logic lowpow);
    if (fast && !lowpow)      return MD_WARP;
    else if (lowpow && !fast) return MD_IMPULSE;
    else                      return MD_NORMAL;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int              WIDTH   = 5,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] fall
);

  // stages 0..STAGES-1 synchronize, stage STAGES keeps the previous level
  logic [STAGES:0][WIDTH-1:0] pipe_q;
  logic [STAGES:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = d;
    for (int i = 1; i <= STAGES; i++) begin
      pipe_d[i] = pipe_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign lvl  = pipe_q[STAGES-1];
  assign fall = pipe_q[STAGES] & ~pipe_q[STAGES-1];

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign zero = (cnt_q == '0);

  always_comb begin
    cnt_en = clr || load || !zero;
    cnt_d  = cnt_q;
    if (clr)        cnt_d = '0;
    else if (load)  cnt_d = load_val;
    else if (!zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CONV_WARP = 298,
  parameter int CONV_NORM = 350,
  parameter int CONV_IMP  = 444,
  parameter int CAL_CYC   = 2000,
  parameter int ACQ_CYC   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_fall,
  input  logic       halt_lvl,
  input  logic       halt_fall,
  input  logic       pd_lvl,
  input  conv_mode_e mode,
  output logic       start_acc,
  output logic       busy,
  output logic       hold,
  output logic       latch_stb,
  output logic       cal_active
);

  localparam int M1 = (CONV_WARP > CONV_NORM) ? CONV_WARP : CONV_NORM;
  localparam int M2 = (M1 > CONV_IMP) ? M1 : CONV_IMP;
  localparam int M3 = (M2 > CAL_CYC) ? M2 : CAL_CYC;
  localparam int M4 = (M3 > ACQ_CYC) ? M3 : ACQ_CYC;
  localparam int TW = $clog2(M4 + 1);

  localparam logic [TW-1:0] LEN_WARP = TW'(CONV_WARP - 1);
  localparam logic [TW-1:0] LEN_NORM = TW'(CONV_NORM - 1);
  localparam logic [TW-1:0] LEN_IMP  = TW'(CONV_IMP - 1);
  localparam logic [TW-1:0] LEN_CAL  = TW'(CAL_CYC - 1);
  localparam logic [TW-1:0] LEN_ACQ  = TW'(ACQ_CYC - 1);

  seq_state_e    state_q, state_d;
  logic          len_load, len_zero;
  logic [TW-1:0] len_val;
  logic          acq_load, acq_zero;

  function automatic logic [TW-1:0] conv_len(input conv_mode_e m);
    case (m)
      MD_WARP:    return LEN_WARP;
      MD_IMPULSE: return LEN_IMP;
      default:    return LEN_NORM;
    endcase
  endfunction

  always_comb begin
    state_d   = state_q;
    len_load  = 1'b0;
    len_val   = '0;
    acq_load  = 1'b0;
    start_acc = 1'b0;
    if (halt_lvl) begin
      state_d = ST_HALT;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_fall && !pd_lvl && acq_zero) begin
            state_d   = ST_CONV;
            start_acc = 1'b1;
            len_load  = 1'b1;
            len_val   = conv_len(mode);
          end
        end
        ST_CONV: begin
          if (len_zero) begin
            state_d  = ST_IDLE;
            acq_load = 1'b1;
          end
        end
        ST_CAL: begin
          if (len_zero) begin
            state_d  = ST_IDLE;
            acq_load = 1'b1;
          end
        end
        ST_HALT: begin
          if (halt_fall) begin
            state_d  = ST_CAL;
            len_load = 1'b1;
            len_val  = LEN_CAL;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  adc_seq_timer #(.CNT_W(TW)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (halt_lvl),
    .load     (len_load),
    .load_val (len_val),
    .zero     (len_zero)
  );

  adc_seq_timer #(.CNT_W(TW)) u_acq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (halt_lvl),
    .load     (acq_load),
    .load_val (LEN_ACQ),
    .zero     (acq_zero)
  );

  assign hold       = (state_q == ST_CONV);
  assign cal_active = (state_q == ST_CAL);
  assign busy       = hold || cal_active;
  assign latch_stb  = hold && len_zero && !halt_lvl;

endmodule

// File: rtl/adc_seq_warp_mon.sv
module adc_seq_warp_mon #(
  parameter int WARP_MAX = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start_acc,
  input  logic start_is_warp,
  output logic err
);

  localparam int CW = $clog2(WARP_MAX + 1);
  localparam logic [CW-1:0] LIM = CW'(WARP_MAX - 1);

  logic          arm_q, arm_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          upd_en;

  always_comb begin
    arm_d  = arm_q;
    cnt_d  = cnt_q;
    err_d  = err_q;
    upd_en = clr || start_acc || arm_q;
    if (clr) begin
      arm_d = 1'b0;
      cnt_d = '0;
      err_d = 1'b0;
    end else if (start_acc) begin
      arm_d = start_is_warp;
      cnt_d = '0;
    end else if (arm_q) begin
      if (cnt_q == LIM) begin
        err_d = 1'b1;
        arm_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (upd_en) begin
      arm_q <= arm_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign err = err_q;

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 18,
  parameter int CONV_WARP   = 298,
  parameter int CONV_NORM   = 350,
  parameter int CONV_IMP    = 444,
  parameter int CAL_CYC     = 2000,
  parameter int ACQ_CYC     = 50,
  parameter int WARP_MAX    = 200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start_n,
  input  logic             cal_rst,
  input  logic             pwr_dn,
  input  logic             sel_fast,
  input  logic             sel_lowpow,
  input  logic [RES_W-1:0] res_in,
  output logic             busy,
  output logic             hold,
  output logic             latch_stb,
  output logic             cal_active,
  output logic [RES_W-1:0] result,
  output logic             warp_err
);

  localparam int NIN = 5;
  // bit order: 0 start, 1 device reset, 2 power-down, 3 fast, 4 low-power
  localparam logic [NIN-1:0] IDLE_VAL = 5'b00001;

  logic [NIN-1:0] raw_in, in_lvl, in_fall;
  logic           start_fall, halt_lvl, halt_fall, pd_lvl;
  conv_mode_e     mode;
  logic           start_acc;
  logic           sync_unused;

  assign raw_in = {sel_lowpow, sel_fast, pwr_dn, cal_rst, conv_start_n};

  adc_seq_sync #(
    .WIDTH   (NIN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IDLE_VAL)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .lvl   (in_lvl),
    .fall  (in_fall)
  );

  assign start_fall  = in_fall[0];
  assign halt_lvl    = in_lvl[1];
  assign halt_fall   = in_fall[1];
  assign pd_lvl      = in_lvl[2];
  assign mode        = decode_mode(in_lvl[3], in_lvl[4]);
  assign sync_unused = ^{in_fall[4:2], in_lvl[0]};

  adc_seq_fsm #(
    .CONV_WARP (CONV_WARP),
    .CONV_NORM (CONV_NORM),
    .CONV_IMP  (CONV_IMP),
    .CAL_CYC   (CAL_CYC),
    .ACQ_CYC   (ACQ_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_fall (start_fall),
    .halt_lvl   (halt_lvl),
    .halt_fall  (halt_fall),
    .pd_lvl     (pd_lvl),
    .mode       (mode),
    .start_acc  (start_acc),
    .busy       (busy),
    .hold       (hold),
    .latch_stb  (latch_stb),
    .cal_active (cal_active)
  );

  adc_seq_warp_mon #(.WARP_MAX(WARP_MAX)) u_warp (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (halt_lvl),
    .start_acc     (start_acc),
    .start_is_warp (mode == MD_WARP),
    .err           (warp_err)
  );

  logic [RES_W-1:0] res_q, res_d;

  always_comb begin
    res_d = res_q;
    if (latch_stb) res_d = res_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         res_q <= '0;
    else if (latch_stb) res_q <= res_d;
  end

  assign result = res_q;

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int RES_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             hold,
  input logic             latch_stb,
  input logic             cal_active,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] res_in,
  input logic             warp_err,
  input logic             halt_lvl,
  input logic             pd_lvl
);

  assert_hold_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> busy);

  assert_latch_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> hold);

  assert_latch_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> (!busy && result == $past(res_in)));

  assert_result_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> $stable(result));

  assert_halt_aborts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_lvl |=> (!busy && !latch_stb));

  assert_cal_no_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_active |-> (busy && !hold && !latch_stb));

  assert_pd_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> !$past(pd_lvl));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warp_err && !halt_lvl) |=> warp_err);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_lvl |=> !warp_err);

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .hold       (hold),
  .latch_stb  (latch_stb),
  .cal_active (cal_active),
  .result     (result),
  .res_in     (res_in),
  .warp_err   (warp_err),
  .halt_lvl   (halt_lvl),
  .pd_lvl     (pd_lvl)
);

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps
module sim_adc_conv_seq;

  localparam int RW   = 18;
  localparam int CW   = 6;
  localparam int CN   = 9;
  localparam int CI   = 13;
  localparam int CAL  = 20;
  localparam int ACQ  = 5;
  localparam int WMAX = 120;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          conv_start_n, cal_rst, pwr_dn, sel_fast, sel_lowpow;
  logic [RW-1:0] res_in;
  logic          busy, hold, latch_stb, cal_active, warp_err;
  logic [RW-1:0] result;

  int checks = 0;
  int errors = 0;
  int latch_cnt = 0;
  bit done = 0;
  logic [RW-1:0] last_res = '0;

  always #2.5 clk = ~clk;

  adc_conv_seq #(
    .RES_W(RW), .CONV_WARP(CW), .CONV_NORM(CN), .CONV_IMP(CI),
    .CAL_CYC(CAL), .ACQ_CYC(ACQ), .WARP_MAX(WMAX), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .cal_rst(cal_rst),
    .pwr_dn(pwr_dn), .sel_fast(sel_fast), .sel_lowpow(sel_lowpow), .res_in(res_in),
    .busy(busy), .hold(hold), .latch_stb(latch_stb), .cal_active(cal_active),
    .result(result), .warp_err(warp_err)
  );

  always @(negedge clk) if (latch_stb === 1'b1) latch_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic f, input logic l);
    if (f && !l)      return CW;
    else if (l && !f) return CI;
    else              return CN;
  endfunction

  task automatic count_busy(output int n, output int holds);
    n = 0; holds = 0;
    while (busy && n < 1000) begin
      n++;
      if (hold) holds++;
      @(negedge clk);
    end
  endtask

  task automatic expect_idle(input int ncyc, input string req);
    int seen = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk(req, seen, 0);
  endtask

  // called at a negedge; returns at the first negedge with busy low
  task automatic run_conv(input logic f, input logic l, input logic [RW-1:0] r, input string tag);
    int n, h, lc0;
    sel_fast = f; sel_lowpow = l; res_in = r;
    conv_start_n = 1'b0;
    lc0 = latch_cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({tag, " R1 busy after start"}, busy, 1);
    chk({tag, " R1 hold after start"}, hold, 1);
    conv_start_n = 1'b1;
    count_busy(n, h);
    chk({tag, " R2 conversion length"}, n, exp_len(f, l));
    chk({tag, " R3 one latch strobe"}, latch_cnt - lc0, 1);
    chk({tag, " R3 result latched"}, result, r);
    last_res = r;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, h, lc0;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; conv_start_n = 1'b1; cal_rst = 1'b0; pwr_dn = 1'b0;
    sel_fast = 1'b0; sel_lowpow = 1'b0; res_in = '0;
    repeat (4) @(negedge clk);
    chk("R11 busy reset", busy, 0);
    chk("R11 hold reset", hold, 0);
    chk("R11 latch reset", latch_stb, 0);
    chk("R11 cal reset", cal_active, 0);
    chk("R11 err reset", warp_err, 0);
    chk("R11 result reset", result, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed: each mode, including both selects high
    run_conv(1'b1, 1'b0, 18'h2A5A5, "R2 fast");
    repeat (ACQ + 2) @(negedge clk);
    run_conv(1'b0, 1'b0, 18'h15A5A, "R2 normal");
    repeat (ACQ + 2) @(negedge clk);
    run_conv(1'b0, 1'b1, 18'h3FFFF, "R2 lowpow");
    repeat (ACQ + 2) @(negedge clk);
    run_conv(1'b1, 1'b1, 18'h00001, "R2 both");
    repeat (ACQ + 2) @(negedge clk);

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      run_conv(m[0], m[1], RW'($urandom), "R2 random");
      repeat ($urandom_range(ACQ, ACQ + 10)) @(negedge clk);
    end
    chk("R9 no error with close spacing", warp_err, 0);

    // R4: start edge during a conversion
    sel_fast = 1'b0; sel_lowpow = 1'b1; res_in = 18'h12345;
    conv_start_n = 1'b0; lc0 = latch_cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    conv_start_n = 1'b1;
    @(negedge clk);
    conv_start_n = 1'b0;
    count_busy(n, h);
    chk("R4 length with extra edge", n + 1, CI);
    chk("R4 single latch", latch_cnt - lc0, 1);
    chk("R4 result", result, 18'h12345);
    last_res = 18'h12345;
    expect_idle(ACQ + 10, "R4 no extra conversion");
    conv_start_n = 1'b1;
    repeat (ACQ + 2) @(negedge clk);

    // R5: acquisition boundary
    run_conv(1'b0, 1'b0, 18'h0F0F0, "R5 setup");
    repeat (ACQ - 4) @(negedge clk);
    conv_start_n = 1'b0;
    expect_idle(ACQ + 8, "R5 early edge ignored");
    conv_start_n = 1'b1;
    repeat (3) @(negedge clk);
    run_conv(1'b0, 1'b0, 18'h0A0A0, "R5 setup2");
    repeat (ACQ - 3) @(negedge clk);
    run_conv(1'b0, 1'b0, 18'h30303, "R5 boundary accepted");
    repeat (ACQ + 2) @(negedge clk);

    // R6: abort by device reset
    sel_fast = 1'b0; sel_lowpow = 1'b1; res_in = 18'h2BEEF;
    conv_start_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 conversion started", busy, 1);
    conv_start_n = 1'b1;
    repeat (3) @(negedge clk);
    cal_rst = 1'b1; lc0 = latch_cnt;
    repeat (4) @(negedge clk);
    chk("R6 busy aborted", busy, 0);
    chk("R6 hold aborted", hold, 0);
    repeat (4) @(negedge clk);
    chk("R6 no latch", latch_cnt - lc0, 0);
    chk("R6 result kept", result, last_res);

    // R7: calibration after reset falls, with start edge inside (R4)
    cal_rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 cal busy", busy, 1);
    chk("R7 cal flag", cal_active, 1);
    conv_start_n = 1'b0;
    count_busy(n, h);
    chk("R7 cal length", n, CAL);
    chk("R7 no hold during cal", h, 0);
    chk("R7 no latch during cal", latch_cnt - lc0, 0);
    chk("R7 result unchanged", result, last_res);
    expect_idle(ACQ + 8, "R4 edge during cal ignored");
    conv_start_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: power-down
    pwr_dn = 1'b1;
    repeat (4) @(negedge clk);
    conv_start_n = 1'b0;
    expect_idle(20, "R8 blocked start");
    conv_start_n = 1'b1;
    pwr_dn = 1'b0;
    repeat (4) @(negedge clk);
    sel_fast = 1'b0; sel_lowpow = 1'b0; res_in = 18'h1C0DE;
    conv_start_n = 1'b0; lc0 = latch_cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 start before power-down", busy, 1);
    conv_start_n = 1'b1;
    pwr_dn = 1'b1;
    count_busy(n, h);
    chk("R8 in-progress length", n, CN);
    chk("R8 in-progress latch", latch_cnt - lc0, 1);
    chk("R8 in-progress result", result, 18'h1C0DE);
    last_res = 18'h1C0DE;
    pwr_dn = 1'b0;
    repeat (ACQ + 4) @(negedge clk);

    // R9: interval limit in fast mode
    sel_fast = 1'b1; sel_lowpow = 1'b0; res_in = 18'h00F00;
    conv_start_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    conv_start_n = 1'b1;
    repeat (WMAX - 1) @(negedge clk);
    chk("R9 no error at limit", warp_err, 0);
    @(negedge clk);
    chk("R9 error one cycle past limit", warp_err, 1);
    run_conv(1'b0, 1'b0, 18'h00ABC, "R9 sticky");
    repeat (5) @(negedge clk);
    chk("R9 error sticky", warp_err, 1);

    // R10: cleared by device reset
    cal_rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 cleared by cal_rst", warp_err, 0);
    cal_rst = 1'b0;
    repeat (3 + CAL + ACQ + 2) @(negedge clk);

    // R9: non-fast start disarms
    run_conv(1'b1, 1'b0, 18'h11111, "R9 arm");
    repeat (ACQ) @(negedge clk);
    run_conv(1'b0, 1'b0, 18'h22222, "R9 disarm");
    repeat (2 * WMAX) @(negedge clk);
    chk("R9 disarmed by normal start", warp_err, 0);

    // R10: cleared by system reset
    run_conv(1'b1, 1'b0, 18'h33333, "R10 arm");
    repeat (WMAX + 5) @(negedge clk);
    chk("R10 error set before reset", warp_err, 1);
    rst_n = 1'b0;
    #1;
    chk("R10 cleared by rst_n", warp_err, 0);
    chk("R11 result cleared by rst_n", result, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule